// File: doc/BRIEF.md
# Flash bus mode and reset sequencer

This block is a clocked model of the control-pin front end of a parallel NOR-style flash device. Each cycle it samples the four active-low control pins (chip select, output enable, write strobe, and the reset/power-down pin). It reports the resulting bus mode and drives the enable for the tri-state data bus. It also tracks the reset pin through its timing rules. A short low pulse is filtered out. A long low pulse puts the device into deep power-down. After release, read data and accepted writes are held back until their own wake-up counts have elapsed.

A program or erase operation is modelled by a start strobe and a busy counter. When the reset pin falls while that counter runs, the operation is aborted, the affected region is flagged as invalid, and a timed shutdown phase follows. The wake-up counts start at the end of that shutdown, not at the release of the pin. If the pin is still low when the shutdown ends, the device goes on into power-down. Each time the device leaves reset, the command state returns to array-read and the status byte is reloaded with 0x80. All timing values are parameters counted in clock cycles.

Top module: `flash_ctl_seq`

## Requirements
- R1: With the reset pin high and the device running, each cycle registers a bus mode from the pins. The codes are: chip select high gives standby (2); otherwise output enable low gives read (0); otherwise write strobe low gives write (3); otherwise output disable (1). The data-bus enable is high only in read mode.
- R2: With chip select high, the data-bus enable is low whatever output enable does. A program/erase started before chip select rose keeps `op_busy` high for exactly T_OP sampled cycles. Status bit 7 is 0 while busy and 1 when done.
- R3: A reset-pin low pulse shorter than T_PLPH samples, taken while idle, is ignored: mode, data-bus enable and `read_valid` stay as they were.
- R4: The reset pin held low for T_PLPH samples while idle gives power-down mode (4) at the T_PLPH-th edge, with the data-bus enable and `read_valid` low.
- R5: After release from power-down, `read_valid` first reads 1 after T_PHQV+1 edges and `write_ready` after T_PHWL+1 edges.
- R6: Leaving reset loads status 0x80 and sets `cmd_read_array`. Starting an operation clears `cmd_read_array`.
- R7: The reset pin falling while `op_busy` is high clears `op_busy` at the next edge, sets the sticky `region_invalid`, and shows mode 4 with the data-bus enable low during shutdown.
- R8: If the reset pin is high when the T_PLRH-cycle shutdown ends, the device enters wake-up directly. `read_valid` returns T_PLRH+T_PHQV edges after the first low sample.
- R9: If the reset pin is still low when the shutdown ends, the device stays in power-down (mode 4). Wake-up timing then runs from the pin's release.
- R10: A write is accepted (`write_acc` high for one cycle) on entry into write mode when `write_ready` was high. Holding the pins in write mode does not repeat the acceptance.
- R11: A write-mode entry while `write_ready` is low is dropped (no `write_acc`) and sets the sticky `wr_err`. A later entry once ready is accepted.
- R12: Under reset: mode standby, data-bus enable low, status 0x80, `cmd_read_array` 1, `read_valid` and `write_ready` 1, and `op_busy`, `wr_err`, `region_invalid` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| rp_n | input | 1 | Reset/power-down pin, active low |
| op_start | input | 1 | Start strobe for a program/erase operation |
| bus_mode | output | 3 | Registered bus mode code |
| dq_oe | output | 1 | Data-bus drive enable |
| write_acc | output | 1 | One-cycle pulse for an accepted write |
| wr_err | output | 1 | Sticky flag for a dropped write |
| read_valid | output | 1 | Read data would be valid |
| write_ready | output | 1 | Writes would be accepted |
| op_busy | output | 1 | Program/erase running |
| status_reg | output | 8 | Status byte, bit 7 = ready |
| cmd_read_array | output | 1 | Command state is array-read |
| region_invalid | output | 1 | Sticky flag: an operation was aborted |

## Verification
The hardest case to reach is the abort whose shutdown ends with the reset pin in either state. It needs an operation in flight and a reset-pin low of a chosen length placed against the shutdown count. The bench starts an operation, then sweeps the low length from one sample to two past the shutdown length. For each length it counts edges until `read_valid` returns, and compares the count with the value computed from the timing parameters. The filtered short pulses are swept the same way, one length at a time, below the power-down threshold.

// File: rtl/fls_seq_pkg.sv
package fls_seq_pkg;
  typedef enum logic [2:0] {
    BM_READ    = 3'd0,
    BM_OUTDIS  = 3'd1,
    BM_STANDBY = 3'd2,
    BM_WRITE   = 3'd3,
    BM_PDOWN   = 3'd4
  } bus_mode_e;

  typedef enum logic [2:0] {
    PH_RUN   = 3'd0,
    PH_RPLOW = 3'd1,
    PH_ABORT = 3'd2,
    PH_PDOWN = 3'd3,
    PH_WAKE  = 3'd4
  } phase_e;

  function automatic bus_mode_e pin_mode(input logic ce_n, input logic oe_n,
                                         input logic we_n, input logic quiet);
    if (quiet)      return BM_PDOWN;
    else if (ce_n)  return BM_STANDBY;
    else if (!oe_n) return BM_READ;
    else if (!we_n) return BM_WRITE;
    else            return BM_OUTDIS;
  endfunction
endpackage

// File: rtl/fls_pin_decode.sv
module fls_pin_decode
  import fls_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      we_n,
  input  logic      quiet_nxt,
  input  logic      wr_ready,
  output bus_mode_e mode_q,
  output logic      dq_oe_q,
  output logic      write_acc_q,
  output logic      wr_err_q
);
  bus_mode_e mode_nxt;
  logic      wr_entry;

  always_comb begin
    mode_nxt = pin_mode(ce_n, oe_n, we_n, quiet_nxt);
    wr_entry = (mode_nxt == BM_WRITE) && (mode_q != BM_WRITE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= BM_STANDBY;
      dq_oe_q     <= 1'b0;
      write_acc_q <= 1'b0;
      wr_err_q    <= 1'b0;
    end else begin
      mode_q      <= mode_nxt;
      dq_oe_q     <= (mode_nxt == BM_READ);
      write_acc_q <= wr_entry && wr_ready;
      if (wr_entry && !wr_ready) wr_err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fls_op_timer.sv
module fls_op_timer #(
  parameter int T_OP = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int OW = $clog2(T_OP + 1);
  localparam logic [OW-1:0] LIM = OW'(T_OP);
  localparam logic [OW-1:0] ONE = OW'(1);

  logic [OW-1:0] ocnt;

  always_comb done = busy && (ocnt == LIM) && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ocnt <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      ocnt <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      ocnt <= ONE;
    end else if (busy) begin
      if (ocnt == LIM) begin
        busy <= 1'b0;
        ocnt <= '0;
      end else begin
        ocnt <= ocnt + ONE;
      end
    end
  end
endmodule

// File: rtl/fls_rst_seq.sv
module fls_rst_seq
  import fls_seq_pkg::*;
#(
  parameter int T_PLPH = 4,
  parameter int T_PLRH = 5,
  parameter int T_PHQV = 3,
  parameter int T_PHWL = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rp_n,
  input  logic       op_start,
  input  logic       op_busy,
  input  logic       op_done,
  output logic       op_go,
  output logic       op_abort,
  output logic       quiet_nxt,
  output logic       read_valid,
  output logic       write_ready,
  output logic [7:0] status_q,
  output logic       cmd_array_q,
  output logic       region_bad_q
);
  localparam int WAKE_MAX = (T_PHQV > T_PHWL) ? T_PHQV : T_PHWL;
  localparam int M1 = (T_PLPH > T_PLRH) ? T_PLPH : T_PLRH;
  localparam int MAXT = (M1 > WAKE_MAX) ? M1 : WAKE_MAX;
  localparam int CW = $clog2(MAXT + 2);
  localparam logic [CW-1:0] LIM_LOW  = CW'(T_PLPH - 1);
  localparam logic [CW-1:0] LIM_ABT  = CW'(T_PLRH - 1);
  localparam logic [CW-1:0] LIM_WAKE = CW'(WAKE_MAX);
  localparam logic [CW-1:0] RD_AT    = CW'(T_PHQV);
  localparam logic [CW-1:0] WR_AT    = CW'(T_PHWL);
  localparam logic [CW-1:0] ONE      = CW'(1);
  localparam logic [7:0]    STAT_RST = 8'h80;

  phase_e        ph, ph_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          wake_entry;

  always_comb begin
    ph_n     = ph;
    cnt_n    = cnt;
    op_abort = 1'b0;
    unique case (ph)
      PH_RUN: begin
        if (!rp_n) begin
          cnt_n = ONE;
          if (op_busy) begin
            ph_n     = PH_ABORT;
            op_abort = 1'b1;
          end else begin
            ph_n = PH_RPLOW;
          end
        end
      end
      PH_RPLOW: begin
        if (rp_n)                ph_n = PH_RUN;
        else if (cnt == LIM_LOW) ph_n = PH_PDOWN;
        else                     cnt_n = cnt + ONE;
      end
      PH_ABORT: begin
        if (cnt == LIM_ABT) begin
          ph_n  = rp_n ? PH_WAKE : PH_PDOWN;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + ONE;
        end
      end
      PH_PDOWN: begin
        if (rp_n) begin
          ph_n  = PH_WAKE;
          cnt_n = '0;
        end
      end
      PH_WAKE: begin
        if (!rp_n)                ph_n = PH_PDOWN;
        else if (cnt == LIM_WAKE) ph_n = PH_RUN;
        else                      cnt_n = cnt + ONE;
      end
      default: ph_n = PH_RUN;
    endcase
  end

  always_comb begin
    quiet_nxt   = (ph_n == PH_ABORT) || (ph_n == PH_PDOWN);
    wake_entry  = (ph_n == PH_WAKE) && (ph != PH_WAKE);
    op_go       = op_start && rp_n && (ph == PH_RUN) && !op_busy;
    read_valid  = (ph == PH_RUN) || (ph == PH_RPLOW) ||
                  ((ph == PH_WAKE) && (cnt >= RD_AT));
    write_ready = (ph == PH_RUN) || (ph == PH_RPLOW) ||
                  ((ph == PH_WAKE) && (cnt >= WR_AT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph           <= PH_RUN;
      cnt          <= '0;
      status_q     <= STAT_RST;
      cmd_array_q  <= 1'b1;
      region_bad_q <= 1'b0;
    end else begin
      ph  <= ph_n;
      cnt <= cnt_n;
      if (op_abort) region_bad_q <= 1'b1;
      if (wake_entry) begin
        status_q    <= STAT_RST;
        cmd_array_q <= 1'b1;
      end else if (op_go) begin
        status_q[7] <= 1'b0;
        cmd_array_q <= 1'b0;
      end else if (op_done) begin
        status_q[7] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_ctl_seq.sv
module flash_ctl_seq
  import fls_seq_pkg::*;
#(
  parameter int T_PLPH = 4,
  parameter int T_PLRH = 5,
  parameter int T_PHQV = 3,
  parameter int T_PHWL = 6,
  parameter int T_OP   = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       rp_n,
  input  logic       op_start,
  output logic [2:0] bus_mode,
  output logic       dq_oe,
  output logic       write_acc,
  output logic       wr_err,
  output logic       read_valid,
  output logic       write_ready,
  output logic       op_busy,
  output logic [7:0] status_reg,
  output logic       cmd_read_array,
  output logic       region_invalid
);
  bus_mode_e mode_q;
  logic      quiet_nxt, op_go, op_abort, op_done;

  fls_rst_seq #(
    .T_PLPH(T_PLPH), .T_PLRH(T_PLRH), .T_PHQV(T_PHQV), .T_PHWL(T_PHWL)
  ) u_seq (
    .clk(clk), .rst(rst), .rp_n(rp_n), .op_start(op_start),
    .op_busy(op_busy), .op_done(op_done), .op_go(op_go), .op_abort(op_abort),
    .quiet_nxt(quiet_nxt), .read_valid(read_valid), .write_ready(write_ready),
    .status_q(status_reg), .cmd_array_q(cmd_read_array),
    .region_bad_q(region_invalid)
  );

  fls_op_timer #(.T_OP(T_OP)) u_op (
    .clk(clk), .rst(rst), .start(op_go), .abort(op_abort),
    .busy(op_busy), .done(op_done)
  );

  fls_pin_decode u_dec (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .quiet_nxt(quiet_nxt), .wr_ready(write_ready), .mode_q(mode_q),
    .dq_oe_q(dq_oe), .write_acc_q(write_acc), .wr_err_q(wr_err)
  );

  always_comb bus_mode = mode_q;
endmodule

// File: rtl/fls_seq_chk.sv
module fls_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       ce_n,
  input logic       oe_n,
  input logic       rp_n,
  input logic [2:0] bus_mode,
  input logic       dq_oe,
  input logic       write_acc,
  input logic       wr_err,
  input logic       read_valid,
  input logic       write_ready,
  input logic       op_busy,
  input logic       region_invalid
);
  a_r1_hiz_when_oe_high: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> !dq_oe);
  a_r2_hiz_when_deselected: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !dq_oe);
  a_r4_pdown_hiz: assert property (@(posedge clk) disable iff (rst)
    (bus_mode == 3'd4) |-> (!dq_oe && !read_valid));
  a_r7_abort_stops_op: assert property (@(posedge clk) disable iff (rst)
    (op_busy && !rp_n) |=> (!op_busy && region_invalid));
  a_r7_invalid_sticky: assert property (@(posedge clk) disable iff (rst)
    region_invalid |=> region_invalid);
  a_r10_accept_needs_ready: assert property (@(posedge clk) disable iff (rst)
    write_acc |-> $past(write_ready));
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err);
endmodule

bind flash_ctl_seq fls_seq_chk u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .rp_n(rp_n),
  .bus_mode(bus_mode), .dq_oe(dq_oe), .write_acc(write_acc), .wr_err(wr_err),
  .read_valid(read_valid), .write_ready(write_ready), .op_busy(op_busy),
  .region_invalid(region_invalid)
);

// File: tb/flash_ctl_seq_bench.sv
`timescale 1ns/1ps
module flash_ctl_seq_bench;
  localparam int T_PLPH = 4;
  localparam int T_PLRH = 5;
  localparam int T_PHQV = 3;
  localparam int T_PHWL = 6;
  localparam int T_OP   = 12;

  logic clk = 1'b0;
  logic rst, ce_n, oe_n, we_n, rp_n, op_start;
  logic [2:0] bus_mode;
  logic dq_oe, write_acc, wr_err, read_valid, write_ready, op_busy;
  logic [7:0] status_reg;
  logic cmd_read_array, region_invalid;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  flash_ctl_seq #(.T_PLPH(T_PLPH), .T_PLRH(T_PLRH), .T_PHQV(T_PHQV),
                  .T_PHWL(T_PHWL), .T_OP(T_OP)) u_flash_ctl_seq (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n),
    .op_start(op_start), .bus_mode(bus_mode), .dq_oe(dq_oe),
    .write_acc(write_acc), .wr_err(wr_err), .read_valid(read_valid),
    .write_ready(write_ready), .op_busy(op_busy), .status_reg(status_reg),
    .cmd_read_array(cmd_read_array), .region_invalid(region_invalid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_mode(input logic c, input logic o, input logic w);
    if (c) return 2;
    if (!o) return 0;
    if (!w) return 3;
    return 1;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int n, rq, wq, seen, rv, expv;
    rst = 1; ce_n = 1; oe_n = 1; we_n = 1; rp_n = 1; op_start = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk("R12 mode", bus_mode, 2);
    chk("R12 dq_oe", dq_oe, 0);
    chk("R12 status", status_reg, 8'h80);
    chk("R12 cmd_read_array", cmd_read_array, 1);
    chk("R12 read_valid", read_valid, 1);
    chk("R12 write_ready", write_ready, 1);
    chk("R12 flags", {op_busy, wr_err, region_invalid}, 0);
    rst = 0;
    @(negedge clk);

    // R1 sweep of all pin combinations
    for (int i = 0; i < 8; i++) begin
      ce_n = i[2]; oe_n = i[1]; we_n = i[0];
      @(negedge clk);
      chk("R1 mode", bus_mode, exp_mode(ce_n, oe_n, we_n));
      chk("R1 dq_oe", dq_oe, int'(exp_mode(ce_n, oe_n, we_n) == 0));
    end

    // R10 write acceptance on entry only
    ce_n = 1; oe_n = 1; we_n = 1;
    @(negedge clk);
    ce_n = 0; we_n = 0;
    @(negedge clk);
    chk("R10 accept on entry", write_acc, 1);
    @(negedge clk);
    chk("R10 no repeat while held", write_acc, 0);
    oe_n = 0;
    @(negedge clk);
    chk("R10 oe low is read", bus_mode, 0);
    chk("R10 no accept in read", write_acc, 0);
    oe_n = 1;
    @(negedge clk);
    chk("R10 re-entry accepted", write_acc, 1);
    we_n = 1;

    // R2 operation continues while deselected
    op_start = 1;
    @(negedge clk);
    op_start = 0; ce_n = 1;
    chk("R2 busy after start", op_busy, 1);
    chk("R2 status busy bit", status_reg[7], 0);
    chk("R6 cmd cleared by op", cmd_read_array, 0);
    n = 1;
    while (op_busy && n < 100) begin
      @(negedge clk);
      if (op_busy) n++;
    end
    chk("R2 busy length", n, T_OP);
    chk("R2 standby mode", bus_mode, 2);
    chk("R2 dq_oe off deselected", dq_oe, 0);
    chk("R2 status ready", status_reg, 8'h80);

    // R3 short reset pulses are ignored
    ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk);
    for (int len = 1; len < T_PLPH; len++) begin
      rp_n = 0;
      repeat (len) @(negedge clk);
      rp_n = 1;
      repeat (2) @(negedge clk);
      chk("R3 mode kept", bus_mode, 0);
      chk("R3 dq_oe kept", dq_oe, 1);
      chk("R3 read_valid kept", read_valid, 1);
    end

    // R4 long low enters power-down
    rp_n = 0;
    repeat (T_PLPH - 1) @(negedge clk);
    chk("R4 not yet down", bus_mode, 0);
    @(negedge clk);
    chk("R4 power-down", bus_mode, 4);
    chk("R4 dq_oe off", dq_oe, 0);
    chk("R4 read_valid off", read_valid, 0);

    // R5 / R6 wake-up timing
    rp_n = 1; rq = 0; wq = 0;
    for (int e = 1; e <= 40; e++) begin
      @(negedge clk);
      if (e == 1) begin
        chk("R6 status reload", status_reg, 8'h80);
        chk("R6 cmd read array", cmd_read_array, 1);
      end
      if (rq == 0 && read_valid) rq = e;
      if (wq == 0 && write_ready) wq = e;
    end
    chk("R5 read wake edges", rq, T_PHQV + 1);
    chk("R5 write wake edges", wq, T_PHWL + 1);

    // R11 write during wake-up is dropped
    rp_n = 0;
    repeat (T_PLPH + 1) @(negedge clk);
    chk("R11 in power-down", bus_mode, 4);
    oe_n = 1; we_n = 0;
    @(negedge clk);
    chk("R11 no error yet", wr_err, 0);
    rp_n = 1; seen = 0;
    repeat (T_PHWL + 3) begin
      @(negedge clk);
      if (write_acc) seen++;
    end
    chk("R11 early write dropped", seen, 0);
    chk("R11 error raised", wr_err, 1);
    we_n = 1;
    @(negedge clk);
    we_n = 0;
    @(negedge clk);
    chk("R11 later write accepted", write_acc, 1);
    chk("R11 error sticky", wr_err, 1);
    we_n = 1;

    // R7 / R8 / R9 abort sweep
    for (int h = 1; h <= T_PLRH + 2; h++) begin
      ce_n = 0; oe_n = 0; we_n = 1; rp_n = 1;
      repeat (10) @(negedge clk);
      op_start = 1;
      @(negedge clk);
      op_start = 0;
      @(negedge clk);
      chk("R7 op running", op_busy, 1);
      rv = 0;
      for (int e = 1; e <= 20; e++) begin
        rp_n = (e > h);
        @(negedge clk);
        if (e == 1) begin
          chk("R7 busy cleared", op_busy, 0);
          chk("R7 region invalid", region_invalid, 1);
          chk("R7 shutdown mode", bus_mode, 4);
          chk("R7 dq_oe off", dq_oe, 0);
        end
        if (h < T_PLRH && e == T_PLRH) chk("R8 direct wake mode", bus_mode, 0);
        if (h > T_PLRH && e == T_PLRH + 1) chk("R9 stays down", bus_mode, 4);
        if (rv == 0 && read_valid) rv = e;
      end
      expv = (h < T_PLRH) ? (T_PLRH + T_PHQV) : (h + 1 + T_PHQV);
      if (h < T_PLRH) chk("R8 read wake after abort", rv, expv);
      else            chk("R9 read wake after release", rv, expv);
    end
    rp_n = 1;
    repeat (10) @(negedge clk);

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule